// File: doc/BRIEF.md
# Bus Access Control Unit

The unit sits in front of a group of on-chip peripherals and judges every bus transfer headed for them. A transfer carries the issuing master's number, a supervisor/user attribute, a flag that marks it as an instruction fetch, a read/write direction and the index of the target peripheral. First, a per-master privilege mask decides whether the master's supervisor attribute is honoured or forced to user. The unit then sorts the transfer into one of six access types: supervisor or user, combined with fetch, read or write. It looks up the rights field of the target and grants or denies the access in the same cycle.

A granted transfer goes through to the target. A denied one never reaches it and is answered one cycle later with an error flag and zero data. The rights live in 8-bit control registers that sit behind a small configuration port. There is one privilege mask, one register for every pair of peripherals, one register for a grouped address space and one for the flash space. Any master may read these registers. Only a master whose own mask bit is set counts as trusted, and only a trusted master may change them.

Top module: `bus_access_ctl`

## Requirements
- R1: After reset the privilege mask reads back as 1 in bit 0 (master 0) and as `trust_init[m-1]` in bit m for m ≥ 1. Every pair register reads 0x88 and both space registers read 0x08, so supervisors may read and write everywhere and users have no access.
- R2: A transfer is treated as supervisor only when `req_sup` is 1 and the mask bit of `req_mid` is 1. Otherwise it is treated as user.
- R3: A transfer with `req_fetch`=1 is a fetch and needs the execute right, whatever `req_write` says. Otherwise `req_write`=1 makes it a write, which needs the write right, and `req_write`=0 makes it a read, which needs the read right.
- R4: A supervisor transfer to an existing index may always read and write. It may fetch only when bit 0 (execute) of the target's field is 1.
- R5: In a user transfer, field bit 3 = 1 (supervisor only) denies everything. Otherwise bit 2 permits reads, bit 1 permits writes and bit 0 permits fetches.
- R6: The 4-bit field of peripheral p (0 ≤ p < N_PERIPH) sits in the pair register at configuration address 1 + p/2: bits [3:0] for even p and bits [7:4] for odd p.
- R7: Index N_PERIPH uses the grouped-space register at address N_PACR+1 and index N_PERIPH+1 uses the flash-space register at address N_PACR+2. Only the low nibble of each is stored and the high nibble reads 0. Higher indices are always denied.
- R8: `acc_grant` is combinational in the request cycle and never high without `req_valid`. A denied request sets `acc_err` for exactly the next cycle with `rsp_rdata` = 0.
- R9: One cycle after a granted read or fetch, `rsp_rdata` equals the `tgt_rdata` of the request cycle and `acc_err` is 0. After a granted write `rsp_rdata` is 0.
- R10: A configuration write by a trusted master, one whose mask bit is 1, takes effect at the clock edge. A read returns the register in `cfg_rdata` one cycle later. The mask is at address 0, and its bits at and above N_MST read 0.
- R11: A configuration write by an untrusted master changes no register and sets `cfg_err` for the next cycle.
- R12: A configuration read or write to an address above N_PACR+2 sets `cfg_err` for the next cycle, returns zero data and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trust_init | input | N_MST-1 | Reset mask bits for masters 1 and up |
| req_valid | input | 1 | Bus transfer present |
| req_mid | input | MW | Issuing master number |
| req_sup | input | 1 | Supervisor attribute from the master |
| req_fetch | input | 1 | Instruction-fetch reference |
| req_write | input | 1 | Write direction |
| req_pidx | input | PW | Target peripheral index |
| tgt_rdata | input | DW | Read data from the target |
| acc_grant | output | 1 | Transfer allowed (same cycle) |
| acc_err | output | 1 | Error response for a denied transfer |
| rsp_rdata | output | DW | Response read data |
| cfg_valid | input | 1 | Configuration access present |
| cfg_write | input | 1 | Configuration write |
| cfg_mid | input | MW | Master issuing the configuration access |
| cfg_addr | input | CAW | Configuration register address |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data |
| cfg_err | output | 1 | Configuration access refused |

## Verification
The properties assume that `req_mid` and `cfg_mid` are always below N_MST while their valid is high. They also assume that the request fields and `tgt_rdata` stay stable inside the cycle in which they are judged, because the grant is combinational. The bench keeps to this: it changes every input only on the falling clock edge and uses only master numbers 0 to 3. Peripheral indices up to 31, including the unmapped ones, are legal stimulus and are exercised deliberately.

// File: rtl/bacu_pkg.sv
package bacu_pkg;

  typedef struct packed {
    logic sup_only;
    logic usr_rd;
    logic usr_wr;
    logic exec;
  } rights_t;

  typedef enum logic [2:0] {
    AT_SUP_FETCH,
    AT_SUP_READ,
    AT_SUP_WRITE,
    AT_USR_FETCH,
    AT_USR_READ,
    AT_USR_WRITE
  } acc_type_t;

  localparam logic [3:0] FIELD_RST = 4'b1000;

  function automatic acc_type_t classify(input logic sup, input logic fetch, input logic wr);
    if (fetch)   return sup ? AT_SUP_FETCH : AT_USR_FETCH;
    else if (wr) return sup ? AT_SUP_WRITE : AT_USR_WRITE;
    else         return sup ? AT_SUP_READ  : AT_USR_READ;
  endfunction

endpackage

// File: rtl/bacu_regs.sv
module bacu_regs #(
  parameter int N_MST  = 4,
  parameter int N_PACR = 9,
  parameter int MW     = 2,
  parameter int CAW    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_MST-2:0]  trust_init,
  input  logic              cfg_valid,
  input  logic              cfg_write,
  input  logic [MW-1:0]     cfg_mid,
  input  logic [CAW-1:0]    cfg_addr,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  output logic              cfg_err,
  output logic [N_MST-1:0]  mpr_o,
  output logic [N_PACR*8-1:0] pacr_o,
  output logic [3:0]        grp_o,
  output logic [3:0]        fls_o
);
  import bacu_pkg::*;

  localparam logic [CAW-1:0] A_GRP  = CAW'(N_PACR + 1);
  localparam logic [CAW-1:0] A_FLS  = CAW'(N_PACR + 2);

  logic [N_MST-1:0] mpr_q;
  logic [7:0]       pacr_q [N_PACR];
  logic [3:0]       grp_q, fls_q;
  logic             in_range, trusted, wr_en;
  logic [7:0]       rd_mux;

  assign in_range = (cfg_addr <= A_FLS);
  assign trusted  = mpr_q[cfg_mid];
  assign wr_en    = cfg_valid & cfg_write & trusted & in_range;

  always_comb begin
    rd_mux = '0;
    if (cfg_addr == '0) rd_mux = 8'(mpr_q);
    if (cfg_addr == A_GRP) rd_mux = {4'h0, grp_q};
    if (cfg_addr == A_FLS) rd_mux = {4'h0, fls_q};
    for (int i = 0; i < N_PACR; i++)
      if (cfg_addr == CAW'(i + 1)) rd_mux = pacr_q[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mpr_q     <= {trust_init, 1'b1};
      grp_q     <= FIELD_RST;
      fls_q     <= FIELD_RST;
      cfg_rdata <= '0;
      cfg_err   <= 1'b0;
      for (int i = 0; i < N_PACR; i++) pacr_q[i] <= {FIELD_RST, FIELD_RST};
    end else begin
      cfg_err   <= cfg_valid & (~in_range | (cfg_write & ~trusted));
      cfg_rdata <= (cfg_valid & ~cfg_write & in_range) ? rd_mux : 8'h00;
      if (wr_en) begin
        if (cfg_addr == '0)    mpr_q <= cfg_wdata[N_MST-1:0];
        if (cfg_addr == A_GRP) grp_q <= cfg_wdata[3:0];
        if (cfg_addr == A_FLS) fls_q <= cfg_wdata[3:0];
        for (int i = 0; i < N_PACR; i++)
          if (cfg_addr == CAW'(i + 1)) pacr_q[i] <= cfg_wdata;
      end
    end
  end

  assign mpr_o = mpr_q;
  assign grp_o = grp_q;
  assign fls_o = fls_q;

  for (genvar g = 0; g < N_PACR; g++) begin : g_flat
    assign pacr_o[g*8 +: 8] = pacr_q[g];
  end

endmodule

// File: rtl/bacu_check.sv
module bacu_check #(
  parameter int N_MST    = 4,
  parameter int N_PERIPH = 17,
  parameter int N_PACR   = 9,
  parameter int MW       = 2,
  parameter int PW       = 5
) (
  input  logic                req_valid,
  input  logic [MW-1:0]       req_mid,
  input  logic                req_sup,
  input  logic                req_fetch,
  input  logic                req_write,
  input  logic [PW-1:0]       req_pidx,
  input  logic [N_MST-1:0]    mpr,
  input  logic [N_PACR*8-1:0] pacr,
  input  logic [3:0]          grp,
  input  logic [3:0]          fls,
  output logic                grant
);
  import bacu_pkg::*;

  logic      eff_sup, hit, allowed;
  rights_t   fld;
  acc_type_t atype;

  assign eff_sup = req_sup & mpr[req_mid];
  assign atype   = classify(eff_sup, req_fetch, req_write);

  always_comb begin
    fld = rights_t'(4'h0);
    hit = 1'b0;
    for (int i = 0; i < N_PERIPH; i++)
      if (req_pidx == PW'(i)) begin
        fld = rights_t'(pacr[i*4 +: 4]);
        hit = 1'b1;
      end
    if (req_pidx == PW'(N_PERIPH)) begin
      fld = rights_t'(grp);
      hit = 1'b1;
    end
    if (req_pidx == PW'(N_PERIPH + 1)) begin
      fld = rights_t'(fls);
      hit = 1'b1;
    end
  end

  always_comb begin
    unique case (atype)
      AT_SUP_FETCH: allowed = fld.exec;
      AT_SUP_READ,
      AT_SUP_WRITE: allowed = 1'b1;
      AT_USR_FETCH: allowed = ~fld.sup_only & fld.exec;
      AT_USR_READ:  allowed = ~fld.sup_only & fld.usr_rd;
      AT_USR_WRITE: allowed = ~fld.sup_only & fld.usr_wr;
      default:      allowed = 1'b0;
    endcase
  end

  assign grant = req_valid & hit & allowed;

endmodule

// File: rtl/bus_access_ctl.sv
module bus_access_ctl #(
  parameter int N_MST    = 4,
  parameter int N_PERIPH = 17,
  parameter int DW       = 32,
  localparam int N_PACR  = (N_PERIPH + 1) / 2,
  localparam int MW      = (N_MST > 1) ? $clog2(N_MST) : 1,
  localparam int PW      = $clog2(N_PERIPH + 2),
  localparam int CAW     = $clog2(N_PACR + 3)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_MST-2:0]  trust_init,
  input  logic              req_valid,
  input  logic [MW-1:0]     req_mid,
  input  logic              req_sup,
  input  logic              req_fetch,
  input  logic              req_write,
  input  logic [PW-1:0]     req_pidx,
  input  logic [DW-1:0]     tgt_rdata,
  output logic              acc_grant,
  output logic              acc_err,
  output logic [DW-1:0]     rsp_rdata,
  input  logic              cfg_valid,
  input  logic              cfg_write,
  input  logic [MW-1:0]     cfg_mid,
  input  logic [CAW-1:0]    cfg_addr,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  output logic              cfg_err
);

  logic [N_MST-1:0]    mpr_w;
  logic [N_PACR*8-1:0] pacr_w;
  logic [3:0]          grp_w, fls_w;

  bacu_regs #(.N_MST(N_MST), .N_PACR(N_PACR), .MW(MW), .CAW(CAW)) u_regs (
    .clk, .rst, .trust_init,
    .cfg_valid, .cfg_write, .cfg_mid, .cfg_addr, .cfg_wdata,
    .cfg_rdata, .cfg_err,
    .mpr_o(mpr_w), .pacr_o(pacr_w), .grp_o(grp_w), .fls_o(fls_w)
  );

  bacu_check #(.N_MST(N_MST), .N_PERIPH(N_PERIPH), .N_PACR(N_PACR), .MW(MW), .PW(PW)) u_check (
    .req_valid, .req_mid, .req_sup, .req_fetch, .req_write, .req_pidx,
    .mpr(mpr_w), .pacr(pacr_w), .grp(grp_w), .fls(fls_w),
    .grant(acc_grant)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      acc_err   <= req_valid & ~acc_grant;
      rsp_rdata <= (acc_grant & (req_fetch | ~req_write)) ? tgt_rdata : '0;
    end
  end

endmodule

// File: rtl/bacu_chk.sv
module bacu_chk #(
  parameter int N_MST    = 4,
  parameter int N_PERIPH = 17,
  parameter int DW       = 32,
  parameter int N_PACR   = 9,
  parameter int MW       = 2,
  parameter int PW       = 5,
  parameter int CAW      = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [MW-1:0]     req_mid,
  input logic              req_sup,
  input logic              req_fetch,
  input logic              req_write,
  input logic [PW-1:0]     req_pidx,
  input logic [DW-1:0]     tgt_rdata,
  input logic              acc_grant,
  input logic              acc_err,
  input logic [DW-1:0]     rsp_rdata,
  input logic              cfg_valid,
  input logic              cfg_write,
  input logic [MW-1:0]     cfg_mid,
  input logic [CAW-1:0]    cfg_addr,
  input logic [7:0]        cfg_rdata,
  input logic              cfg_err,
  input logic [N_MST-1:0]  mpr_w,
  input logic [N_PACR*8-1:0] pacr_w,
  input logic [3:0]        grp_w,
  input logic [3:0]        fls_w
);

  logic [N_MST+N_PACR*8+7:0] state_all;
  assign state_all = {mpr_w, pacr_w, grp_w, fls_w};

  p_grant_needs_valid_r8: assert property (@(posedge clk) disable iff (rst)
    acc_grant |-> req_valid);

  p_deny_err_r8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !acc_grant) |=> (acc_err && rsp_rdata == '0));

  p_read_data_r9: assert property (@(posedge clk) disable iff (rst)
    (acc_grant && !req_write) |=> (!acc_err && rsp_rdata == $past(tgt_rdata)));

  p_sup_rw_r4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_sup && mpr_w[req_mid] && !req_fetch && req_pidx <= PW'(N_PERIPH + 1))
      |-> acc_grant);

  p_unmapped_deny_r7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_pidx > PW'(N_PERIPH + 1)) |-> !acc_grant);

  p_blocked_write_r11: assert property (@(posedge clk) disable iff (rst)
    (cfg_valid && cfg_write && !mpr_w[cfg_mid]) |=> (cfg_err && state_all == $past(state_all)));

  p_bad_addr_r12: assert property (@(posedge clk) disable iff (rst)
    (cfg_valid && cfg_addr > CAW'(N_PACR + 2)) |=> (cfg_err && cfg_rdata == 8'h00 && state_all == $past(state_all)));

endmodule

bind bus_access_ctl bacu_chk #(
  .N_MST(N_MST), .N_PERIPH(N_PERIPH), .DW(DW), .N_PACR(N_PACR), .MW(MW), .PW(PW), .CAW(CAW)
) u_chk (
  .clk, .rst, .req_valid, .req_mid, .req_sup, .req_fetch, .req_write, .req_pidx,
  .tgt_rdata, .acc_grant, .acc_err, .rsp_rdata,
  .cfg_valid, .cfg_write, .cfg_mid, .cfg_addr, .cfg_rdata, .cfg_err,
  .mpr_w, .pacr_w, .grp_w, .fls_w
);

// File: tb/tb_bus_access_ctl.sv
module tb_bus_access_ctl;

  localparam int N_MST = 4, N_PERIPH = 17, DW = 32;
  localparam int VN = 24;

  logic clk = 1'b0, rst = 1'b1;
  logic [2:0] trust_init = 3'b001;
  logic req_valid = 0, req_sup = 0, req_fetch = 0, req_write = 0;
  logic [1:0] req_mid = 0, cfg_mid = 0;
  logic [4:0] req_pidx = 0;
  logic [DW-1:0] tgt_rdata = 0, rsp_rdata;
  logic acc_grant, acc_err;
  logic cfg_valid = 0, cfg_write = 0, cfg_err;
  logic [3:0] cfg_addr = 0;
  logic [7:0] cfg_wdata = 0, cfg_rdata;

  int compared = 0, mismatched = 0;
  bit done = 0;

  always #5 clk = ~clk;

  bus_access_ctl #(.N_MST(N_MST), .N_PERIPH(N_PERIPH), .DW(DW)) dut (.*);

  // {mid, sup, fetch, write, pidx, expected grant}
  localparam logic [10:0] VEC [VN] = '{
    {2'd0,1'b1,1'b0,1'b0,5'd0, 1'b1}, {2'd0,1'b1,1'b0,1'b1,5'd0, 1'b1},
    {2'd0,1'b1,1'b1,1'b0,5'd0, 1'b0}, {2'd0,1'b0,1'b0,1'b0,5'd0, 1'b1},
    {2'd0,1'b0,1'b0,1'b1,5'd0, 1'b0}, {2'd0,1'b0,1'b0,1'b1,5'd1, 1'b1},
    {2'd0,1'b0,1'b0,1'b0,5'd1, 1'b0}, {2'd0,1'b0,1'b1,1'b0,5'd2, 1'b1},
    {2'd0,1'b1,1'b1,1'b0,5'd2, 1'b1}, {2'd0,1'b0,1'b0,1'b0,5'd2, 1'b0},
    {2'd0,1'b0,1'b0,1'b0,5'd3, 1'b0}, {2'd0,1'b1,1'b0,1'b1,5'd3, 1'b1},
    {2'd2,1'b1,1'b0,1'b0,5'd3, 1'b0}, {2'd1,1'b1,1'b0,1'b0,5'd3, 1'b1},
    {2'd3,1'b0,1'b0,1'b0,5'd17,1'b1}, {2'd3,1'b0,1'b0,1'b1,5'd17,1'b1},
    {2'd3,1'b1,1'b1,1'b0,5'd17,1'b0}, {2'd0,1'b1,1'b1,1'b0,5'd18,1'b1},
    {2'd0,1'b0,1'b0,1'b0,5'd18,1'b0}, {2'd0,1'b1,1'b0,1'b0,5'd19,1'b0},
    {2'd0,1'b1,1'b0,1'b0,5'd31,1'b0}, {2'd1,1'b1,1'b0,1'b0,5'd4, 1'b1},
    {2'd2,1'b0,1'b0,1'b0,5'd4, 1'b0}, {2'd0,1'b0,1'b1,1'b1,5'd2, 1'b1}
  };

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg_op(input logic [1:0] mid, input logic wr, input logic [3:0] addr,
                        input logic [7:0] wd, output logic [7:0] rd, output logic err);
    @(negedge clk);
    cfg_valid = 1; cfg_mid = mid; cfg_write = wr; cfg_addr = addr; cfg_wdata = wd;
    @(negedge clk);
    rd = cfg_rdata; err = cfg_err;
    cfg_valid = 0; cfg_write = 0;
  endtask

  task automatic bus_op(input string req, input logic [1:0] mid, input logic sup, input logic fetch,
                        input logic wr, input logic [4:0] pidx, input logic exp, input logic [DW-1:0] data);
    @(negedge clk);
    req_valid = 1; req_mid = mid; req_sup = sup; req_fetch = fetch; req_write = wr;
    req_pidx = pidx; tgt_rdata = data;
    #1 chk({req, " grant"}, DW'(acc_grant), DW'(exp));
    @(negedge clk);
    chk({req, " R8 err"}, DW'(acc_err), DW'(!exp));
    chk({req, " R9 rdata"}, rsp_rdata, (exp && (fetch || !wr)) ? data : '0);
    req_valid = 0;
  endtask

  initial begin
    logic [7:0] rd;
    logic err;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 acc_err", DW'(acc_err), 0);
    cfg_op(0, 0, 0, 0, rd, err);  chk("R1 mask", DW'(rd), 32'h03); chk("R1 err", DW'(err), 0);
    cfg_op(3, 0, 1, 0, rd, err);  chk("R1 pair0", DW'(rd), 32'h88);
    cfg_op(3, 0, 9, 0, rd, err);  chk("R1 pair8", DW'(rd), 32'h88);
    cfg_op(2, 0, 10, 0, rd, err); chk("R1 group", DW'(rd), 32'h08);
    cfg_op(2, 0, 11, 0, rd, err); chk("R1 flash", DW'(rd), 32'h08);
    bus_op("R1 R4 sup read", 0, 1, 0, 0, 5, 1, 32'h1111_0001);
    bus_op("R1 R5 user read", 0, 0, 0, 0, 5, 0, 32'h1111_0002);
    bus_op("R1 R4 sup fetch", 0, 1, 1, 0, 5, 0, 32'h1111_0003);

    // R10 trusted configuration, R6 layout, R7 space register nibble
    cfg_op(0, 1, 1, 8'h24, rd, err);  chk("R10 wr err", DW'(err), 0);
    cfg_op(0, 1, 2, 8'h81, rd, err);
    cfg_op(1, 1, 10, 8'hF6, rd, err); chk("R10 m1 wr err", DW'(err), 0);
    cfg_op(0, 1, 11, 8'h0D, rd, err);
    cfg_op(2, 0, 1, 0, rd, err);  chk("R10 R6 readback", DW'(rd), 32'h24);
    cfg_op(2, 0, 10, 0, rd, err); chk("R7 group high nibble", DW'(rd), 32'h06);
    cfg_op(2, 0, 11, 0, rd, err); chk("R7 flash", DW'(rd), 32'h0D);

    // R11 untrusted write
    cfg_op(2, 1, 1, 8'h00, rd, err); chk("R11 err", DW'(err), 1);
    cfg_op(0, 0, 1, 0, rd, err);     chk("R11 unchanged", DW'(rd), 32'h24);

    // Table: R2 R3 R4 R5 R6 R7
    for (int i = 0; i < VN; i++)
      bus_op($sformatf("R3/R5 vec%0d", i), VEC[i][10:9], VEC[i][8], VEC[i][7], VEC[i][6],
             VEC[i][5:1], VEC[i][0], 32'h5A00_0000 | DW'(i));

    // R2 master 0 loses trust
    cfg_op(0, 1, 0, 8'h02, rd, err); chk("R2 mask wr", DW'(err), 0);
    cfg_op(3, 0, 0, 0, rd, err);     chk("R2 mask rd", DW'(rd), 32'h02);
    bus_op("R2 forced user", 0, 1, 0, 0, 3, 0, 32'h2222_0001);
    cfg_op(0, 1, 2, 8'h00, rd, err); chk("R2 R11 err", DW'(err), 1);
    cfg_op(1, 0, 2, 0, rd, err);     chk("R11 unchanged2", DW'(rd), 32'h81);
    cfg_op(1, 1, 0, 8'hFF, rd, err); chk("R10 m1 restore", DW'(err), 0);
    cfg_op(1, 0, 0, 0, rd, err);     chk("R10 mask upper zero", DW'(rd), 32'h0F);

    // R12 unmapped configuration addresses
    cfg_op(0, 1, 13, 8'h55, rd, err); chk("R12 wr err", DW'(err), 1);
    cfg_op(0, 0, 14, 0, rd, err);     chk("R12 rd err", DW'(err), 1); chk("R12 rd zero", DW'(rd), 0);
    cfg_op(0, 0, 0, 0, rd, err);      chk("R12 mask intact", DW'(rd), 32'h0F);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      compared++; mismatched++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule